// File: doc/BRIEF.md
# Linked-List DMA Node Walker

This block is a DMA sequencer that follows a chain of packets stored in RAM and streams their payload words to one peripheral port. A typical target is a graphics command port that takes draw commands and configuration words. Each packet starts with a 32-bit header word. The low 24 bits of the header hold the byte address of the next packet. The top 8 bits hold how many payload words follow the header. Software writes the chain, then pulses `start` with the address of the first packet. The walker then runs with no further help: it reads the header, forwards each payload word in turn, jumps to the next packet, and stops at the end marker.

RAM is read through a request/acknowledge port. A request stays up with a fixed address until the memory acknowledges it, and the read data is taken in the acknowledge cycle. Payload goes out through a single holding register with a valid/ready handshake, so a slow sink throttles the RAM reads. A limit on visited nodes guards against a corrupted chain that loops back on itself. When the walk hits that limit it is aborted and an error is flagged.

Top module: `lldma_walker`

## Requirements
- R1: The first read after an accepted `start` is at `start_addr`. Header bits [23:0] give the byte address of the next header to read, and header bits [31:24] give its payload word count.
- R2: The payload words of a node are read from the header address plus 4, plus 8, and so on, one word per count. They appear on `out_data` in that order, each word exactly once.
- R3: A header whose count field is zero forwards no payload, and the walk still goes on to its next-address field.
- R4: A next-address field of 0xFFFFFF ends the walk, after the payload of that last node has been read. `done` is then high for exactly one cycle, and in that cycle `busy` and `mem_req` are low.
- R5: While `out_valid` is high and `out_ready` is low, `out_data` holds steady and no payload read is issued. A word is never dropped or overwritten.
- R6: Once `mem_req` is raised, it stays high with `mem_addr` unchanged until the cycle in which `mem_ack` is high.
- R7: If the node whose header is number MAX_NODES of a walk has no end marker, the walk aborts after that node's payload. `err` then rises together with the `done` pulse and stays high until the next accepted `start`. A chain of exactly MAX_NODES nodes that ends properly completes without error.
- R8: A `start` pulse while `busy` is high is ignored. The walk in progress is not disturbed.
- R9: After reset, `busy`, `done`, `err`, `mem_req` and `out_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a walk (taken only when idle) |
| start_addr | input | 24 | Byte address of the first header |
| busy | output | 1 | High while a walk is in progress |
| done | output | 1 | One-cycle pulse when a walk ends or aborts |
| err | output | 1 | Node limit reached; holds until the next start |
| mem_req | output | 1 | RAM read request |
| mem_addr | output | 24 | RAM read byte address |
| mem_ack | input | 1 | RAM read acknowledge; data valid in this cycle |
| mem_rdata | input | 32 | RAM read data |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Sink accepts the word this cycle |

## Verification
The hardest situation to reach from the ports is a payload read that wants to issue while the holding register is still full. This needs a sink that stalls exactly when a word has just been loaded and more payload remains. The bench gets there by holding `out_ready` low from the start of a four-word node. It then checks that `mem_req` drops and that the first word stays on the output. It also runs the same chains under several ready duty patterns and memory latencies. A second hard case is a looping chain, built in bench memory, which reaches the node limit. A chain of exactly the limit length sits next to it as the boundary case.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LINK_W     = 24;
  localparam int unsigned SPAN_W     = WORD_W - LINK_W;
  localparam int unsigned WORD_BYTES = WORD_W / 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LINK_W-1:0] link_t;
  typedef logic [SPAN_W-1:0] span_t;

  localparam link_t TAIL_MARK = '1;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_HEAD,
    WK_BODY
  } walk_state_t;

  // next-packet address carried in a header word
  function automatic link_t link_of(word_t w);
    return w[LINK_W-1:0];
  endfunction

  // payload word count carried in a header word
  function automatic span_t span_of(word_t w);
    return w[WORD_W-1 -: SPAN_W];
  endfunction

  function automatic logic is_tail(link_t a);
    return a == TAIL_MARK;
  endfunction

  // address of the word following a
  function automatic link_t step_addr(link_t a);
    return a + link_t'(WORD_BYTES);
  endfunction

endpackage

// File: rtl/lldma_out_reg.sv
module lldma_out_reg
  import lldma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_data,
  output logic  out_valid,
  output word_t out_data,
  input  logic  out_ready,
  output logic  slot_free
);

  // a new word may be captured when empty or when the held word leaves now
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/lldma_node_guard.sv
module lldma_node_guard #(
  parameter int unsigned MAX_NODES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic node_inc,
  output logic last_node
);

  localparam int unsigned CNT_W = $clog2(MAX_NODES + 1);

  logic [CNT_W-1:0] visited;

  // the node being finished is the final one allowed
  assign last_node = visited == CNT_W'(MAX_NODES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      visited <= '0;
    else if (clear)
      visited <= '0;
    else if (node_inc)
      visited <= visited + 1'b1;
  end

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
  import lldma_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  link_t start_addr,
  output logic  mem_req,
  output link_t mem_addr,
  input  logic  mem_ack,
  input  word_t mem_rdata,
  input  logic  slot_free,
  input  logic  last_node,
  output logic  node_clear,
  output logic  node_inc,
  output logic  load,
  output logic  busy,
  output logic  done,
  output logic  err,
  output logic  hdr_fire,
  output logic  pay_fire,
  output logic  walk_end,
  output logic  walk_abort
);

  walk_state_t state;
  link_t       rd_addr;
  link_t       next_link;
  span_t       left;
  logic        pending;
  logic        done_q;
  logic        err_q;

  logic        fire;
  logic        node_done;
  link_t       hop;

  // header reads never wait; payload reads wait for room unless already posted
  assign mem_req  = (state == WK_HEAD) ||
                    ((state == WK_BODY) && (pending || slot_free));
  assign mem_addr = rd_addr;
  assign fire     = mem_req && mem_ack;
  assign hdr_fire = fire && (state == WK_HEAD);
  assign pay_fire = fire && (state == WK_BODY);

  assign node_done = (hdr_fire && (span_of(mem_rdata) == '0)) ||
                     (pay_fire && (left == span_t'(1)));
  assign hop        = hdr_fire ? link_of(mem_rdata) : next_link;
  assign walk_end   = node_done && is_tail(hop);
  assign walk_abort = node_done && !is_tail(hop) && last_node;

  assign node_clear = (state == WK_IDLE) && start;
  assign node_inc   = node_done;
  assign load       = pay_fire;
  assign busy       = state != WK_IDLE;
  assign done       = done_q;
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= WK_IDLE;
      rd_addr   <= '0;
      next_link <= '0;
      left      <= '0;
      pending   <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q  <= walk_end || walk_abort;
      pending <= mem_req && !mem_ack;
      unique case (state)
        WK_IDLE: begin
          if (start) begin
            state   <= WK_HEAD;
            rd_addr <= start_addr;
            err_q   <= 1'b0;
          end
        end
        WK_HEAD: begin
          if (hdr_fire && !node_done) begin
            state     <= WK_BODY;
            rd_addr   <= step_addr(rd_addr);
            left      <= span_of(mem_rdata);
            next_link <= link_of(mem_rdata);
          end
        end
        WK_BODY: begin
          if (pay_fire && !node_done) begin
            rd_addr <= step_addr(rd_addr);
            left    <= left - 1'b1;
          end
        end
        default: state <= WK_IDLE;
      endcase
      if (node_done) begin
        if (walk_end || walk_abort) begin
          state <= WK_IDLE;
        end else begin
          state   <= WK_HEAD;
          rd_addr <= hop;
        end
        if (walk_abort) err_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/lldma_walker.sv
module lldma_walker #(
  parameter int unsigned MAX_NODES = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] start_addr,
  output logic        busy,
  output logic        done,
  output logic        err,
  output logic        mem_req,
  output logic [23:0] mem_addr,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        out_valid,
  output logic [31:0] out_data,
  input  logic        out_ready
);

  logic slot_free;
  logic last_node;
  logic node_clear;
  logic node_inc;
  logic load;
  logic hdr_fire;
  logic pay_fire;
  logic walk_end;
  logic walk_abort;

  lldma_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_addr (start_addr),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .slot_free  (slot_free),
    .last_node  (last_node),
    .node_clear (node_clear),
    .node_inc   (node_inc),
    .load       (load),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .hdr_fire   (hdr_fire),
    .pay_fire   (pay_fire),
    .walk_end   (walk_end),
    .walk_abort (walk_abort)
  );

  lldma_node_guard #(.MAX_NODES(MAX_NODES)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (node_clear),
    .node_inc  (node_inc),
    .last_node (last_node)
  );

  lldma_out_reg u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_data (mem_rdata),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .slot_free (slot_free)
  );

endmodule

// File: rtl/lldma_walker_chk.sv
module lldma_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        err,
  input logic        mem_req,
  input logic [23:0] mem_addr,
  input logic        mem_ack,
  input logic        out_valid,
  input logic [31:0] out_data,
  input logic        out_ready,
  input logic        hdr_fire,
  input logic        pay_fire,
  input logic        walk_end,
  input logic        walk_abort
);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pay_fire |-> (!out_valid || out_ready));

  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req));

  p_end_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_end |=> (done && !err));

  p_abort_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    walk_abort |=> (done && err));

  p_err_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_one_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hdr_fire, pay_fire}) <= 1);

endmodule

bind lldma_walker lldma_walker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_ready  (out_ready),
  .hdr_fire   (hdr_fire),
  .pay_fire   (pay_fire),
  .walk_end   (walk_end),
  .walk_abort (walk_abort)
);

// File: tb/test_lldma_walker.sv
module test_lldma_walker;

  localparam int LIMIT    = 4;
  localparam int WATCHDOG = 150000;
  localparam int NROWS    = 6;
  // row: start[39:16] latency[15:12] ready_mode[11:8] expected_words[7:0]
  localparam logic [39:0] VEC [NROWS] = '{
    {24'h000010, 4'd0, 4'd1, 8'd5},
    {24'h000010, 4'd2, 4'd2, 8'd5},
    {24'h000200, 4'd1, 4'd3, 8'd4},
    {24'h000380, 4'd1, 4'd1, 8'd4},
    {24'h000300, 4'd0, 4'd1, 8'd0},
    {24'h0003A0, 4'd0, 4'd2, 8'd4}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        busy, done, err, mem_req, out_valid;
  logic [23:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] out_data;
  logic        out_ready = 1'b0;

  lldma_walker #(.MAX_NODES(LIMIT)) i_lldma_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .err(err),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  always #2 clk = ~clk;

  logic [31:0] mem [256];
  int checks = 0, errors = 0, cyc = 0;
  int mem_lat = 0, lat_cnt = 0, rdy_mode = 1;
  logic [31:0] cap [64];
  logic [23:0] rlog [64];
  int cap_n = 0, log_n = 0, done_n = 0, r6_bad = 0;
  logic prev_wait = 1'b0;
  logic [23:0] prev_addr = '0;
  logic [31:0] exp_word [64];
  logic [23:0] exp_addr [64];
  int exp_n, exp_an;
  logic exp_err;

  always @(posedge clk) begin
    cyc++;
    if (cyc == WATCHDOG) begin
      checks++; errors++;
      $display("FAIL R4 watchdog: cycles %0d expected below %0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
    #1;
    case (rdy_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = (cyc % rdy_mode) == 0;
    endcase
  end

  // memory responder, output capture and handshake monitor
  always @(negedge clk) begin
    if (out_valid && out_ready && cap_n < 64) begin cap[cap_n] = out_data; cap_n++; end
    if (done) done_n++;
    if (prev_wait && (!mem_req || mem_addr != prev_addr)) r6_bad++;
    if (mem_req) begin
      if (lat_cnt >= mem_lat) begin
        mem_ack = 1'b1; mem_rdata = mem[mem_addr[9:2]]; lat_cnt = 0;
        if (log_n < 64) begin rlog[log_n] = mem_addr; log_n++; end
      end else begin
        mem_ack = 1'b0; lat_cnt++;
      end
    end else begin
      mem_ack = 1'b0; lat_cnt = 0;
    end
    prev_wait = mem_req && !mem_ack;
    prev_addr = mem_addr;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic put_node(input logic [23:0] a, input logic [23:0] nx, input logic [7:0] n);
    mem[a[9:2]] = {n, nx};
    for (int k = 1; k <= int'(n); k++) begin
      logic [23:0] pa = a + 24'(4 * k);
      mem[pa[9:2]] = 32'hA000_0000 | 32'(pa);
    end
  endtask

  // independent software walk of the chain in bench memory
  task automatic model_walk(input logic [23:0] s);
    logic [23:0] a = s;
    int nodes = 0;
    exp_n = 0; exp_an = 0; exp_err = 1'b0;
    for (int g = 0; g < 16; g++) begin
      logic [31:0] h = mem[a[9:2]];
      exp_addr[exp_an] = a; exp_an++;
      nodes++;
      for (int k = 1; k <= int'(h[31:24]); k++) begin
        logic [23:0] pa = a + 24'(4 * k);
        exp_addr[exp_an] = pa; exp_an++;
        exp_word[exp_n] = mem[pa[9:2]]; exp_n++;
      end
      if (h[23:0] == 24'hFFFFFF) break;
      if (nodes == LIMIT) begin exp_err = 1'b1; break; end
      a = h[23:0];
    end
  endtask

  task automatic pulse_start(input logic [23:0] a);
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_case(input logic [23:0] s, input int lat, input int mode,
                          input int expn, input string tag, input bit intrude, input bit stall);
    model_walk(s);
    cap_n = 0; log_n = 0; done_n = 0;
    mem_lat = lat; rdy_mode = stall ? 0 : mode;
    pulse_start(s);
    if (intrude) pulse_start(24'h000300);            // R8: ignored while busy
    if (stall) begin
      repeat (15) @(negedge clk);
      chk(out_valid == 1'b1, "R5", 32'(out_valid), 32'd1, "held valid under stall");
      chk(out_data == exp_word[0], "R5", out_data, exp_word[0], "held word under stall");
      chk(mem_req == 1'b0, "R5", 32'(mem_req), 32'd0, "no read while full");
      rdy_mode = mode;
    end
    for (int i = 0; i < 3000 && done_n == 0; i++) @(negedge clk);
    for (int i = 0; i < 100 && out_valid; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(done_n == 1, "R4", 32'(done_n), 32'd1, "done pulses");
    chk(busy == 1'b0, "R4", 32'(busy), 32'd0, "busy after walk");
    chk(cap_n == expn && cap_n == exp_n, tag, 32'(cap_n), 32'(expn), "payload word count");
    for (int i = 0; i < exp_n && i < cap_n; i++)
      chk(cap[i] == exp_word[i], "R2", cap[i], exp_word[i], "payload word");
    chk(log_n == exp_an, "R1", 32'(log_n), 32'(exp_an), "read count");
    for (int i = 0; i < exp_an && i < log_n; i++)
      chk(rlog[i] == exp_addr[i], "R1", 32'(rlog[i]), 32'(exp_addr[i]), "read address");
    chk(err == exp_err, "R7", 32'(err), 32'(exp_err), "error flag");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    put_node(24'h000010, 24'h000040, 8'd2);
    put_node(24'h000040, 24'h000100, 8'd0);        // R3: zero-count node mid-chain
    put_node(24'h000100, 24'hFFFFFF, 8'd3);
    put_node(24'h000200, 24'hFFFFFF, 8'd4);
    put_node(24'h000300, 24'hFFFFFF, 8'd0);
    put_node(24'h000380, 24'h000390, 8'd1);        // R7: two-node loop
    put_node(24'h000390, 24'h000380, 8'd1);
    put_node(24'h0003A0, 24'h0003B0, 8'd1);        // exactly LIMIT nodes
    put_node(24'h0003B0, 24'h0003C0, 8'd1);
    put_node(24'h0003C0, 24'h0003D0, 8'd0);
    put_node(24'h0003D0, 24'hFFFFFF, 8'd2);

    repeat (3) @(negedge clk);
    // R9: reset state
    chk(busy == 1'b0, "R9", 32'(busy), 32'd0, "busy in reset");
    chk(mem_req == 1'b0, "R9", 32'(mem_req), 32'd0, "mem_req in reset");
    chk(out_valid == 1'b0, "R9", 32'(out_valid), 32'd0, "out_valid in reset");
    chk(done == 1'b0 && err == 1'b0, "R9", {30'd0, done, err}, 32'd0, "done/err in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int r = 0; r < NROWS; r++) begin
      string tag;
      case (r)
        0, 4: tag = "R3";
        1: tag = "R5";
        3, 5: tag = "R7";
        default: tag = "R2";
      endcase
      run_case(VEC[r][39:16], int'(VEC[r][15:12]), int'(VEC[r][11:8]),
               int'(VEC[r][7:0]), tag, 1'b0, 1'b0);
    end

    // R8: second start during a walk leaves it untouched
    run_case(24'h000200, 1, 1, 4, "R8", 1'b1, 1'b0);
    // R5: sink stalled from the first payload word
    run_case(24'h000200, 0, 1, 4, "R5", 1'b0, 1'b1);
    // R7: error holds while idle, then clears on the next start
    run_case(24'h000380, 0, 1, 4, "R7", 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(err == 1'b1, "R7", 32'(err), 32'd1, "error held while idle");
    run_case(24'h000300, 0, 1, 0, "R7", 1'b0, 1'b0);

    chk(r6_bad == 0, "R6", 32'(r6_bad), 32'd0, "request dropped or moved before ack");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule